// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and verifies the even-parity bit for a shared 32-bit address/data bus that carries a 4-bit command/byte-enable field beside it. The transaction sequencer tells it about each bus cycle: whether the cycle is an address phase or a data phase, whether this agent is the initiator, which way the data flows, whether the transaction was claimed, and whether a data transfer completed. The block uses that to decide when to drive the parity line and when to check it. It keeps no protocol state of its own.

Parity always covers the value the bus carried one clock earlier. The local agent drives the parity line only when it was the source of that value. When the agent received the value, it compares the incoming parity one clock later. A mismatch on a completed, claimed data phase produces a one-clock low pulse on the data-error output. A mismatch on an address phase produces a one-clock low pulse on the system-error output. Each kind of error also sets a sticky flag. Software clears a sticky flag with a write-one-to-clear strobe.

Top module: `bus_parity_unit`

## Requirements
- R1: `par_out` in cycle k equals the XOR of all bits of `ad_in` and `cbe_in` from cycle k-1, so that those 36 bits together with `par_out` hold an even number of ones.
- R2: `par_oe` is 1 in cycle k when cycle k-1 was an address phase with `is_master`=1, or a data cycle (`data_cyc`=1) with `is_master`=1 and `is_write`=1.
- R3: `par_oe` is 1 in cycle k when cycle k-1 was a data cycle with `is_master`=0 and `is_write`=0. In every other case `par_oe` is 0.
- R4: `perr_n` is 0 for exactly one clock in cycle k+2 when cycle k had `data_xfer`=1 and `devsel`=1, this agent was the receiver (`is_master` differs from `is_write`), and `par_in` in cycle k+1 differs from the parity of cycle k's `ad_in`/`cbe_in`.
- R5: A parity mismatch on a data cycle with `devsel`=0 or `data_xfer`=0 leaves `perr_n` at 1.
- R6: A parity mismatch on a data phase that this agent sourced (`is_master` equals `is_write`) leaves `perr_n` at 1.
- R7: `serr_n` is 0 for exactly one clock in cycle k+2 when cycle k had `addr_phase`=1 and `par_in` in cycle k+1 mismatches. The role of the agent does not matter.
- R8: `dpe_flag` and `ape_flag` become 1 in the same cycle as the corresponding `perr_n` or `serr_n` pulse. They stay at 1 until `clr_dpe` or `clr_ape` is 1 at a clock edge. If a new error arrives at the same edge as the clear, the new error wins.
- R9: While `rst_n` is 0: `par_oe`=0, `par_out`=0, `perr_n`=1, `serr_n`=1, and both sticky flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ad_in | input | 32 | Address/data lines as seen on the bus |
| cbe_in | input | 4 | Command/byte-enable lines as seen on the bus |
| par_in | input | 1 | Parity line as seen on the bus |
| addr_phase | input | 1 | Current cycle is an address phase |
| data_cyc | input | 1 | Current cycle is a data cycle (completed or waiting) |
| data_xfer | input | 1 | A data phase completes this cycle |
| devsel | input | 1 | Transaction has been claimed by a target |
| is_master | input | 1 | Local agent is the initiator |
| is_write | input | 1 | Transaction moves data from initiator to target |
| clr_dpe | input | 1 | Write-one-to-clear strobe for `dpe_flag` |
| clr_ape | input | 1 | Write-one-to-clear strobe for `ape_flag` |
| par_out | output | 1 | Generated parity bit |
| par_oe | output | 1 | Drive enable for the parity line |
| perr_n | output | 1 | Data parity error pulse, active low |
| serr_n | output | 1 | Address parity error pulse, active low |
| dpe_flag | output | 1 | Sticky data parity error flag |
| ape_flag | output | 1 | Sticky address parity error flag |

## Verification
The hardest situations to reach are the ones where a corrupted parity bit must be ignored: an unclaimed transfer, a stalled data cycle, and a phase the local agent sourced. The other hard case is an error that arrives on the same edge as the clear strobe of its sticky flag. Random stimulus mixes roles, directions, claim state and completion on every cycle, and flips the incoming parity on about a quarter of the cycles, so these combinations come up often. Directed sequences then force a bad address phase, an unclaimed bad data phase, and an error that coincides with its clear strobe.

// File: rtl/bus_parity_unit.sv
module bus_parity_unit #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_in,
  input  logic [CBE_W-1:0] cbe_in,
  input  logic             par_in,
  input  logic             addr_phase,
  input  logic             data_cyc,
  input  logic             data_xfer,
  input  logic             devsel,
  input  logic             is_master,
  input  logic             is_write,
  input  logic             clr_dpe,
  input  logic             clr_ape,
  output logic             par_out,
  output logic             par_oe,
  output logic             perr_n,
  output logic             serr_n,
  output logic             dpe_flag,
  output logic             ape_flag
);

  logic par_q, oe_q, chk_d_q, chk_a_q, perr_q, serr_q, dpe_q, ape_q;

  wire par_now  = ^{ad_in, cbe_in};
  wire sourcing = (is_master == is_write);
  wire mismatch = (par_in != par_q);
  wire d_err    = chk_d_q && mismatch;
  wire a_err    = chk_a_q && mismatch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_q   <= 1'b0;
      oe_q    <= 1'b0;
      chk_d_q <= 1'b0;
      chk_a_q <= 1'b0;
      perr_q  <= 1'b0;
      serr_q  <= 1'b0;
      dpe_q   <= 1'b0;
      ape_q   <= 1'b0;
    end else begin
      par_q   <= par_now;
      oe_q    <= (addr_phase && is_master) || (data_cyc && !addr_phase && sourcing);
      chk_d_q <= data_xfer && devsel && !addr_phase && !sourcing;
      chk_a_q <= addr_phase;
      perr_q  <= d_err;
      serr_q  <= a_err;
      dpe_q   <= d_err || (dpe_q && !clr_dpe);
      ape_q   <= a_err || (ape_q && !clr_ape);
    end
  end

  assign par_out  = par_q;
  assign par_oe   = oe_q;
  assign perr_n   = !perr_q;
  assign serr_n   = !serr_q;
  assign dpe_flag = dpe_q;
  assign ape_flag = ape_q;

  // R1: driven parity makes the previous cycle's 37 bits even
  a_r1_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (^{$past(ad_in), $past(cbe_in), par_out}) == 1'b0);

  // R2: master address phase is followed by a driven parity bit
  a_r2_master_addr_drive: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase && is_master |=> par_oe);

  // R4, R5, R6: a data error pulse needs a claimed, completed, received phase
  a_r4_perr_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> $past(devsel, 2) && $past(data_xfer, 2) &&
                ($past(is_master, 2) != $past(is_write, 2)));

  // R7: a system error pulse follows an address phase
  a_r7_serr_from_addr: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n |-> $past(addr_phase, 2));

  // R8: sticky flags accompany the pulses and hold without a clear
  a_r8_dpe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> dpe_flag);
  a_r8_ape_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ape_flag && !clr_ape |=> ape_flag);

endmodule

// File: tb/bus_parity_unit_test.sv
module bus_parity_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_in = '0;
  logic par_in = 1'b0, addr_phase = 1'b0, data_cyc = 1'b0, data_xfer = 1'b0;
  logic devsel = 1'b0, is_master = 1'b0, is_write = 1'b0, clr_dpe = 1'b0, clr_ape = 1'b0;
  logic par_out, par_oe, perr_n, serr_n, dpe_flag, ape_flag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // stimulus history: p1 = previous cycle, p2 = two cycles ago
  logic [35:0] p1_bits = '0, p2_bits = '0;
  logic p1_addr = 0, p1_data = 0, p1_xfer = 0, p1_dev = 0, p1_mst = 0, p1_wr = 0;
  logic p1_par = 0, p1_cd = 0, p1_ca = 0;
  logic p2_addr = 0, p2_xfer = 0, p2_dev = 0, p2_mst = 0, p2_wr = 0;
  logic exp_dpe = 0, exp_ape = 0;

  bus_parity_unit uut (.*);

  always #4 clk = ~clk;

  function automatic logic par36(input logic [35:0] b);
    return ^b;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b cycle=%0d", req, act, exp, cycles);
    end
  endtask

  // compare outputs of the cycle that just began, then record history and drive new inputs
  task automatic step(input logic a, input logic dc, input logic dx, input logic dv,
                      input logic m, input logic w, input logic flip,
                      input logic cd, input logic ca);
    logic e_perr, e_serr, e_oe;
    @(negedge clk);
    cycles++;
    e_oe   = (p1_addr && p1_mst) || (p1_data && !p1_addr && (p1_mst == p1_wr));
    e_perr = p2_xfer && p2_dev && !p2_addr && (p2_mst != p2_wr) && (p1_par != par36(p2_bits));
    e_serr = p2_addr && (p1_par != par36(p2_bits));
    exp_dpe = e_perr || (exp_dpe && !p1_cd);
    exp_ape = e_serr || (exp_ape && !p1_ca);
    chk("R1 par_out", par_out, par36(p1_bits));
    chk(p1_mst == p1_wr ? "R2 par_oe" : "R3 par_oe", par_oe, e_oe);
    chk((p2_mst == p2_wr) ? "R6 perr_n" : (p2_dev && p2_xfer) ? "R4 perr_n" : "R5 perr_n",
        perr_n, !e_perr);
    chk("R7 serr_n", serr_n, !e_serr);
    chk("R8 dpe_flag", dpe_flag, exp_dpe);
    chk("R8 ape_flag", ape_flag, exp_ape);
    p2_bits = p1_bits; p2_addr = p1_addr; p2_xfer = p1_xfer; p2_dev = p1_dev;
    p2_mst = p1_mst; p2_wr = p1_wr;
    par_in = par36(p1_bits) ^ flip;
    ad_in = $urandom(); cbe_in = 4'($urandom());
    addr_phase = a; data_cyc = dc; data_xfer = dx; devsel = dv;
    is_master = m; is_write = w; clr_dpe = cd; clr_ape = ca;
    p1_bits = {ad_in, cbe_in}; p1_addr = a; p1_data = dc; p1_xfer = dx; p1_dev = dv;
    p1_mst = m; p1_wr = w; p1_par = par_in; p1_cd = cd; p1_ca = ca;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 par_oe", par_oe, 1'b0);
    chk("R9 par_out", par_out, 1'b0);
    chk("R9 perr_n", perr_n, 1'b1);
    chk("R9 serr_n", serr_n, 1'b1);
    chk("R9 dpe_flag", dpe_flag, 1'b0);
    chk("R9 ape_flag", ape_flag, 1'b0);
    rst_n = 1'b1;
    // directed: bad address phase seen as target (R7)
    step(1, 0, 0, 0, 0, 1, 0, 0, 0);
    step(0, 1, 1, 1, 0, 1, 1, 0, 0);
    // directed: bad write data unclaimed (R5), then claimed (R4)
    step(0, 1, 1, 0, 0, 1, 1, 0, 0);
    step(0, 1, 1, 1, 0, 1, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, 1, 0, 0);
    // directed: bad read data sourced by target (R6)
    step(0, 1, 1, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0);
    // directed: error on the same edge as its clear (R8)
    step(0, 1, 1, 1, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 1, 1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    // random traffic across roles, directions, claims and parity faults
    for (int i = 0; i < 3000; i++) begin
      logic a;
      a = ($urandom_range(3) == 0);
      step(a, !a && $urandom_range(1), !a && $urandom_range(1), 1'($urandom()),
           1'($urandom()), 1'($urandom()), ($urandom_range(3) == 0),
           ($urandom_range(7) == 0), ($urandom_range(7) == 0));
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule